// File: doc/BRIEF.md
# Frame-Gated Serial DAC Word Loader

This block takes 16-bit converter words from a three-wire serial link and holds the current converter code in a latch. An active-low frame signal opens a frame. Data bits are shifted in, most significant bit first, on falling edges of the serial clock. A bit counter admits exactly sixteen falling edges per frame and ignores every later edge until the next frame opens. Because of this, the serial clock may run freely or come in bursts.

The level of an active-low load strobe is sampled at the moment a frame opens, and it picks one of two update modes:
- **Automatic** (strobe low): the latch takes the completed word on the sixteenth clock edge.
- **Strobed** (strobe high): the completed word waits until the strobe falls.

A configuration input selects reduced resolution. In that mode the first fourteen bits of the frame are the code and the last two bits are discarded. After every latch load, a settling timer withholds the output-valid flag for a programmable number of system clocks. An asynchronous active-low clear empties the latch and abandons any frame or update in progress. All inputs are assumed to be already synchronous to the single system clock.

Top module: `serial_dac_loader`

## Requirements
- R1: A falling edge of `frame_n` opens a frame. Each later falling edge of `ser_clk` (sampled on the system clock) shifts `ser_din` in, most significant bit first. In automatic mode, `dac_code` shows the assembled 16-bit word from the system clock edge that detects the sixteenth falling serial-clock edge.
- R2: After sixteen bits, further `ser_clk` falling edges in the same frame change neither the captured word nor `dac_code`.
- R3: If `load_n` is high when the frame opens, `dac_code` stays unchanged at the sixteenth edge and takes the completed word on the system clock edge that detects the next falling edge of `load_n`.
- R4: A falling edge of `load_n` has no effect when no completed strobed-mode word is waiting, including in automatic mode.
- R5: If `frame_n` rises before sixteen bits have arrived, the partial word is discarded and `dac_code` keeps its value.
- R6: When `low_res` is 1 at the load, `dac_code` is the received word shifted right by two: bits 15..14 are zero and bits 13..0 are the first fourteen received bits.
- R7: `code_valid` is 0 on the clock after a latch load and rises exactly `SETTLE_CYC` system clocks after the load edge.
- R8: `proto_err` pulses high for one clock when a frame opens with `load_n` low and the previous frame was in strobed mode. It stays low for a frame opening after an automatic-mode frame.
- R9: While `clr_n` is low, `dac_code` and `code_valid` are 0 at once, with no clock needed. The clear also cancels a waiting strobed update and abandons the current frame, so later serial edges in that frame load nothing.
- R10: Synchronous `rst` sets `dac_code` and `code_valid` to 0 and keeps `proto_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low latch clear |
| low_res | input | 1 | 1 selects 14-bit resolution |
| frame_n | input | 1 | Active-low frame sync |
| ser_clk | input | 1 | Serial clock; data taken on falling edges |
| ser_din | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load strobe / mode select |
| dac_code | output | 16 | Latched converter code |
| code_valid | output | 1 | Code has settled after the last load |
| proto_err | output | 1 | One-clock pulse on a strobe-still-low frame start |

## Verification
A strobed-mode word that is still waiting can be released by a falling `load_n` in the very cycle that `frame_n` falls to open the next frame. In that one cycle the block must load the old word, raise `proto_err`, and select automatic mode for the new frame. The bench drives both falling edges on the same clock. It checks that the old word appears and `proto_err` pulses for exactly one clock, and then that the following sixteen bits load automatically. The bench also uses an asynchronous clear with a strobed update waiting, and it judges that case by the absence of a load on the later strobe.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int WORD_W = 16;
    localparam int LOW_W  = 14;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        UPD_AUTO   = 1'b0,
        UPD_STROBE = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic fr_fall;
        logic sc_fall;
        logic ld_fall;
    } edge_s;

    function automatic word_t fmt_code(word_t w, logic low_res);
        word_t r;
        r = low_res ? word_t'(w >> (WORD_W - LOW_W)) : w;
        return r;
    endfunction

endpackage

// File: rtl/sdl_frame_ctrl.sv
module sdl_frame_ctrl
    import sdl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic frame_n,
    input  logic ser_clk,
    input  logic load_n,
    output logic shift_en,
    output logic ld_auto,
    output logic ld_strobe,
    output logic proto_err
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    logic            fr_q, sc_q, ld_q;
    edge_s           edg;
    logic [CNT_W-1:0] bit_cnt;
    logic            running;
    logic            pending;
    upd_mode_e       mode;

    always_comb begin
        edg.fr_fall = fr_q & ~frame_n;
        edg.sc_fall = sc_q & ~ser_clk;
        edg.ld_fall = ld_q & ~load_n;
    end

    assign shift_en  = running & ~frame_n & edg.sc_fall;
    assign ld_auto   = shift_en & (bit_cnt == LAST_BIT) & (mode == UPD_AUTO);
    assign ld_strobe = pending & edg.ld_fall;

    // Edge history, mode and error pulse: synchronous reset only
    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q      <= 1'b1;
            sc_q      <= 1'b1;
            ld_q      <= 1'b1;
            mode      <= UPD_AUTO;
            proto_err <= 1'b0;
        end else begin
            fr_q      <= frame_n;
            sc_q      <= ser_clk;
            ld_q      <= load_n;
            proto_err <= edg.fr_fall & ~load_n & (mode == UPD_STROBE);
            if (edg.fr_fall)
                mode <= load_n ? UPD_STROBE : UPD_AUTO;
        end
    end

    // Bit counter and pending update: also cleared asynchronously
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            bit_cnt <= '0;
            running <= 1'b0;
            pending <= 1'b0;
        end else if (rst) begin
            bit_cnt <= '0;
            running <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (ld_strobe)
                pending <= 1'b0;
            if (edg.fr_fall) begin
                bit_cnt <= '0;
                running <= 1'b1;
                pending <= 1'b0;
            end else if (frame_n) begin
                running <= 1'b0;
            end else if (shift_en) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    running <= 1'b0;
                    if (mode == UPD_STROBE)
                        pending <= 1'b1;
                end
            end
        end
    end

    // R2
    full_count_hold_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (bit_cnt == FULL_CNT) && !edg.fr_fall |=> (bit_cnt == FULL_CNT));

    // R8
    proto_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(fr_q) && !$past(frame_n) && !$past(load_n)));

endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter
    import sdl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  ser_din,
    output word_t held_word,
    output word_t next_word
);

    word_t sr;

    assign next_word = {sr[WORD_W-2:0], ser_din};
    assign held_word = sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (shift_en)
            sr <= next_word;
    end

endmodule

// File: rtl/sdl_latch.sv
module sdl_latch
    import sdl_pkg::*;
#(
    parameter int SETTLE_CYC = 500
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_n,
    input  logic  ld,
    input  word_t ld_word,
    input  logic  low_res,
    output word_t code,
    output logic  code_valid
);

    localparam int TMR_W = $clog2(SETTLE_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(SETTLE_CYC);

    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            code       <= '0;
            code_valid <= 1'b0;
            tmr        <= '0;
        end else if (rst) begin
            code       <= '0;
            code_valid <= 1'b0;
            tmr        <= '0;
        end else if (ld) begin
            code       <= fmt_code(ld_word, low_res);
            code_valid <= 1'b0;
            tmr        <= TMR_LOAD;
        end else if (tmr != '0) begin
            tmr <= tmr - 1'b1;
            if (tmr == TMR_W'(1))
                code_valid <= 1'b1;
        end
    end

    // R4
    code_only_on_load_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !ld |=> $stable(code));

    // R6
    low_res_top_zero_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (ld && low_res) |=> (code[WORD_W-1:LOW_W] == '0));

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        ld |=> !code_valid);

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (code == '0 && !code_valid));

endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
    import sdl_pkg::*;
#(
    parameter int SETTLE_CYC = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              low_res,
    input  logic              frame_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              load_n,
    output logic [WORD_W-1:0] dac_code,
    output logic              code_valid,
    output logic              proto_err
);

    logic  shift_en, ld_auto, ld_strobe;
    word_t held_word, next_word, ld_word;

    sdl_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .frame_n   (frame_n),
        .ser_clk   (ser_clk),
        .load_n    (load_n),
        .shift_en  (shift_en),
        .ld_auto   (ld_auto),
        .ld_strobe (ld_strobe),
        .proto_err (proto_err)
    );

    sdl_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .ser_din   (ser_din),
        .held_word (held_word),
        .next_word (next_word)
    );

    assign ld_word = ld_auto ? next_word : held_word;

    sdl_latch #(.SETTLE_CYC(SETTLE_CYC)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .ld         (ld_auto | ld_strobe),
        .ld_word    (ld_word),
        .low_res    (low_res),
        .code       (dac_code),
        .code_valid (code_valid)
    );

    // R3
    single_load_src_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !(ld_auto && ld_strobe));

endmodule

// File: tb/serial_dac_loader_bench.sv
module serial_dac_loader_bench;

    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        low_res = 1'b0;
    logic        frame_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic        ser_din = 1'b0;
    logic        load_n = 1'b1;
    logic [15:0] dac_code;
    logic        code_valid;
    logic        proto_err;

    int compared = 0;
    int mismatched = 0;
    logic [15:0] exp_code;

    always #5 clk = ~clk;

    serial_dac_loader #(.SETTLE_CYC(SETTLE)) u_serial_dac_loader (
        .clk(clk), .rst(rst), .clr_n(clr_n), .low_res(low_res),
        .frame_n(frame_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .load_n(load_n), .dac_code(dac_code), .code_valid(code_valid),
        .proto_err(proto_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic open_frame(input bit strobed);
        load_n  = strobed;
        frame_n = 1'b0;
        tick();
        load_n = 1'b1;
        tick();
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_din = (i < 16) ? w[15 - i] : ~w[i % 16];
            ser_clk = 1'b0;
            tick();
            ser_clk = 1'b1;
            tick();
        end
    endtask

    task automatic close_frame();
        frame_n = 1'b1;
        tick();
    endtask

    task automatic strobe();
        load_n = 1'b0;
        tick();
        load_n = 1'b1;
        tick();
    endtask

    function automatic logic [15:0] fmt(input logic [15:0] w, input bit lr);
        return lr ? (w >> 2) : w;
    endfunction

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] w;
        bit strobed, lr;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        check("R10", dac_code, 16'h0);
        check("R10", code_valid, 1'b0);
        check("R10", proto_err, 1'b0);

        // R7 settle timing on an automatic load
        open_frame(1'b0);
        w = 16'hA5C3;
        send_bits(w, 16);           // now one clock past the load edge
        check("R1", dac_code, w);
        check("R7", code_valid, 1'b0);
        tick(); tick();
        check("R7", code_valid, 1'b0);
        tick();
        check("R7", code_valid, 1'b1);
        close_frame();
        exp_code = w;

        // Sweep: walking ones and their complements, both modes and resolutions
        for (int k = 0; k < 32; k++) begin
            w       = (k < 16) ? (16'h1 << k) : ~(16'h1 << (k - 16));
            strobed = k[0];
            lr      = k[1];
            low_res = lr;
            open_frame(strobed);
            send_bits(w, 16);
            if (strobed) begin
                check("R3", dac_code, exp_code);
                close_frame();
                strobe();
                exp_code = fmt(w, lr);
                check(lr ? "R6" : "R3", dac_code, exp_code);
            end else begin
                exp_code = fmt(w, lr);
                check(lr ? "R6" : "R1", dac_code, exp_code);
                close_frame();
            end
        end
        low_res = 1'b0;

        // R2 lockout: 20 edges, strobed, only first 16 taken
        open_frame(1'b1);
        w = 16'h3C96;
        send_bits(w, 20);
        check("R2", dac_code, exp_code);
        close_frame();
        strobe();
        exp_code = w;
        check("R2", dac_code, exp_code);
        // R2 lockout in automatic mode
        open_frame(1'b0);
        w = 16'h7E18;
        send_bits(w, 20);
        exp_code = w;
        check("R2", dac_code, exp_code);
        close_frame();

        // R4 strobe in automatic mode / without a completed word
        strobe();
        check("R4", dac_code, exp_code);
        // R8 negative: frame opens with strobe low after auto frame
        load_n = 1'b0; frame_n = 1'b0;
        tick();
        check("R8", proto_err, 1'b0);
        load_n = 1'b1;
        tick();
        // R5 partial frame
        send_bits(16'hFFFF, 10);
        close_frame();
        check("R5", dac_code, exp_code);
        open_frame(1'b1);
        send_bits(16'h1234, 10);
        close_frame();
        strobe();
        check("R5", dac_code, exp_code);

        // Coincidence: pending strobed word released as next frame opens
        open_frame(1'b1);
        w = 16'hBEEF;
        send_bits(w, 16);
        close_frame();
        load_n = 1'b0; frame_n = 1'b0;
        tick();
        exp_code = w;
        check("R3", dac_code, exp_code);
        check("R8", proto_err, 1'b1);
        load_n = 1'b1;
        tick();
        check("R8", proto_err, 1'b0);
        w = 16'h0F5A;
        send_bits(w, 16);
        exp_code = w;
        check("R1", dac_code, exp_code);
        close_frame();

        // R9 clear cancels pending update
        open_frame(1'b1);
        send_bits(16'hC0DE, 16);
        close_frame();
        clr_n = 1'b0;
        #1;
        check("R9", dac_code, 16'h0);
        check("R9", code_valid, 1'b0);
        tick();
        clr_n = 1'b1;
        tick();
        strobe();
        check("R9", dac_code, 16'h0);
        // R9 clear abandons a frame in progress
        open_frame(1'b0);
        send_bits(16'h9999, 8);
        clr_n = 1'b0;
        tick();
        clr_n = 1'b1;
        tick();
        send_bits(16'h9999, 8);
        check("R9", dac_code, 16'h0);
        close_frame();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule